// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a word-addressed memory with two fully independent ports, A and B. Each port has its own clock and its own synchronous reset. Each port can read or write any word while the other port is busy. On every rising edge of its clock, a port registers its chip enables, its write strobe and its write data. The address used by a port is held in a burst counter. The external address bus reaches that counter only when the port's load strobe is asserted. While the count enable is held, the counter then steps through consecutive words, which gives bursts of reads or writes without a new address on every cycle.

A static select input, shared by both ports, sets the read path. In flow-through mode, read data follows the captured address in the same cycle. In pipelined mode, the data passes through an extra output register and so appears one clock later. Each port has two chip enables, one active low and one active high. A deselected port writes nothing, drives zeros on its read data and holds its valid flag low.

When both ports write the same word in the same cycle, the stored result is undefined. A system using the block must avoid that case or tolerate it.

Top module: `burst_dual_port_ram`

## Requirements
- R1: Either port can write any word and either port can read it back. Two writes on different ports to different words in the same cycle both take effect.
- R2: A write captured on a rising edge is committed at the next edge of that port's clock. A flow-through read captured on the same edge as the write returns the old word, and a read captured on the following edge or later returns the new word.
- R3: With `flow_sel`=1 (flow-through), a read captured on a rising edge shows its word on `rdata` shortly after that edge, with `rvalid`=1 in the same cycle.
- R4: With `flow_sel`=0 (pipelined), a read captured on a rising edge shows its word on `rdata`, with `rvalid`=1, one clock after the capture. During the capture cycle the outputs still show the previous access.
- R5: When `load_n` is low on an edge, the counter takes the value of `addr`, and that access uses it. When `clr_n`, `load_n` and `step_n` are all high, the access address is unchanged and `addr` is ignored.
- R6: When `step_n` is low on an edge, and neither `clr_n` nor `load_n` is low, the counter advances by one word. Successive edges therefore reach successive words.
- R7: Stepping from the last word, 2^ADDR_W-1, wraps the counter to word 0.
- R8: When `clr_n` is low on an edge, the counter goes to 0. The priority order is `clr_n` over `load_n` over `step_n`. The counter obeys these inputs whether or not the port is selected.
- R9: A port is selected only when `sel_n`=0 and `sel`=1. An access captured while deselected writes nothing and yields `rdata`=0 and `rvalid`=0, in the same cycle in flow-through mode and one cycle later in pipelined mode. In pipelined mode, a port returning from deselect therefore shows valid data only one clock after its first selected read is captured.
- R10: `rvalid` is 1 only for a selected read (`we`=0). A write access yields `rvalid`=0, and `rdata` is 0 whenever `rvalid` is 0.
- R11: While reset is held, and right after it, both ports show `rvalid`=0 and `rdata`=0, and each counter is at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flow_sel | input | 1 | Read path select, shared by both ports: 1 flow-through, 0 pipelined; static between resets |
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| sel_n_a | input | 1 | Port A chip enable, active low |
| sel_a | input | 1 | Port A chip enable, active high |
| we_a | input | 1 | Port A write strobe, 1 writes, 0 reads |
| load_n_a | input | 1 | Port A counter load from `addr_a`, active low |
| step_n_a | input | 1 | Port A counter increment, active low |
| clr_n_a | input | 1 | Port A counter clear, active low |
| addr_a | input | ADDR_W | Port A load address |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A read data, 0 when not valid |
| rvalid_a | output | 1 | Port A read data valid |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| sel_n_b | input | 1 | Port B chip enable, active low |
| sel_b | input | 1 | Port B chip enable, active high |
| we_b | input | 1 | Port B write strobe |
| load_n_b | input | 1 | Port B counter load from `addr_b`, active low |
| step_n_b | input | 1 | Port B counter increment, active low |
| clr_n_b | input | 1 | Port B counter clear, active low |
| addr_b | input | ADDR_W | Port B load address |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B read data, 0 when not valid |
| rvalid_b | output | 1 | Port B read data valid |

## Verification
The output properties look one or two port-clock edges into the past and interpret what they find through the current value of `flow_sel`. They are therefore sound only if that select holds still from one reset to the next. The stimulus moves `flow_sel` only while both resets are asserted, and holds reset for several cycles afterwards, so every register the properties reason about starts out cleared. The properties also take it that each port's inputs settle between edges. The bench drives all inputs one nanosecond after a rising edge and samples there as well. No check ever targets a word that both ports wrote in the same cycle.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

    // Read path selection; the encoding matches the flow_sel input pin.
    typedef enum logic {
        RD_PIPE = 1'b0,
        RD_FLOW = 1'b1
    } rd_mode_e;

    // Counter operation for the coming edge.
    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_STEP  = 2'd1,
        CNT_LOAD  = 2'd2,
        CNT_CLEAR = 2'd3
    } cnt_op_e;

    // Access attributes captured at a port's input register.
    typedef struct packed {
        logic sel;   // port was enabled
        logic wr;    // access is a write
    } acc_flags_t;

    // Resolves the active-low counter controls: clear, then load, then step.
    function automatic cnt_op_e cnt_decode(input logic clr_n,
                                           input logic load_n,
                                           input logic step_n);
        cnt_op_e op;
        if (!clr_n)       op = CNT_CLEAR;
        else if (!load_n) op = CNT_LOAD;
        else if (!step_n) op = CNT_STEP;
        else              op = CNT_HOLD;
        return op;
    endfunction

    // Port is enabled only with the low enable low and the high enable high.
    function automatic logic port_enabled(input logic en_lo, input logic en_hi);
        return !en_lo && en_hi;
    endfunction

endpackage

// File: rtl/dpr_burst_ctr.sv
`timescale 1ns/1ps
module dpr_burst_ctr
    import dpr_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_op_e       op,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST_WORD = {AW{1'b1}};

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            unique case (op)
                CNT_CLEAR: ptr_q <= '0;
                CNT_LOAD:  ptr_q <= load_val;
                CNT_STEP:  ptr_q <= (ptr_q == LAST_WORD) ? '0 : ptr_q + 1'b1;
                default:   ptr_q <= ptr_q;
            endcase
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/dpr_out_stage.sv
`timescale 1ns/1ps
module dpr_out_stage
    import dpr_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_mode_e      mode,
    input  logic          rd_ok,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] flow_d;
    logic [DW-1:0] pipe_d;
    logic          pipe_v;

    // Data for the access in flight, forced to zero when it is not a read.
    assign flow_d = rd_ok ? rd_word : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_d <= '0;
            pipe_v <= 1'b0;
        end else begin
            pipe_d <= flow_d;
            pipe_v <= rd_ok;
        end
    end

    always_comb begin
        if (mode == RD_FLOW) begin
            rdata  = flow_d;
            rvalid = rd_ok;
        end else begin
            rdata  = pipe_d;
            rvalid = pipe_v;
        end
    end

endmodule

// File: rtl/dpr_port.sv
`timescale 1ns/1ps
module dpr_port
    import dpr_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_mode_e      mode,
    input  logic          en_lo,
    input  logic          en_hi,
    input  logic          we,
    input  logic          load_n,
    input  logic          step_n,
    input  logic          clr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_en,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    acc_flags_t    acc_q;
    logic [DW-1:0] wdata_q;
    logic [AW-1:0] ptr;
    cnt_op_e       op;

    assign op = cnt_decode(clr_n, load_n, step_n);

    dpr_burst_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (addr),
        .ptr      (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            wdata_q <= '0;
        end else begin
            acc_q.sel <= port_enabled(en_lo, en_hi);
            acc_q.wr  <= we;
            wdata_q   <= wdata;
        end
    end

    assign wr_en    = acc_q.sel && acc_q.wr;
    assign acc_addr = ptr;
    assign wr_data  = wdata_q;

    dpr_out_stage #(.DW(DW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .rd_ok   (acc_q.sel && !acc_q.wr),
        .rd_word (rd_word),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

endmodule

// File: rtl/dpr_lvt_store.sv
`timescale 1ns/1ps
module dpr_lvt_store #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 8
) (
    input  logic          clk_a,
    input  logic          we_a,
    input  logic [AW-1:0] wa_a,
    input  logic [DW-1:0] wd_a,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic          clk_b,
    input  logic          we_b,
    input  logic [AW-1:0] wa_b,
    input  logic [DW-1:0] wd_b,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_b
);
    localparam int unsigned DEPTH   = 1 << AW;
    localparam int unsigned N_READS = 2;

    // One bank per writer; tag_a ^ tag_b per word names the newest writer
    // (0: bank A, 1: bank B). Each tag vector has a single writer.
    logic [DW-1:0]    bank_a [DEPTH];
    logic [DW-1:0]    bank_b [DEPTH];
    logic [DEPTH-1:0] tag_a;
    logic [DEPTH-1:0] tag_b;

    always_ff @(posedge clk_a) begin
        if (we_a) begin
            bank_a[wa_a] <= wd_a;
            tag_a[wa_a]  <= tag_b[wa_a];
        end
    end

    always_ff @(posedge clk_b) begin
        if (we_b) begin
            bank_b[wa_b] <= wd_b;
            tag_b[wa_b]  <= ~tag_a[wa_b];
        end
    end

    logic [AW-1:0] rd_addr [N_READS];
    logic [DW-1:0] rd_word [N_READS];

    assign rd_addr[0] = ra_a;
    assign rd_addr[1] = ra_b;

    for (genvar g = 0; g < N_READS; g++) begin : g_rd
        assign rd_word[g] = (tag_a[rd_addr[g]] ^ tag_b[rd_addr[g]])
                          ? bank_b[rd_addr[g]] : bank_a[rd_addr[g]];
    end

    assign rd_a = rd_word[0];
    assign rd_b = rd_word[1];

endmodule

// File: rtl/burst_dual_port_ram.sv
`timescale 1ns/1ps
module burst_dual_port_ram
    import dpr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 8
) (
    input  logic              flow_sel,
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              sel_n_a,
    input  logic              sel_a,
    input  logic              we_a,
    input  logic              load_n_a,
    input  logic              step_n_a,
    input  logic              clr_n_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] rdata_a,
    output logic              rvalid_a,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              sel_n_b,
    input  logic              sel_b,
    input  logic              we_b,
    input  logic              load_n_b,
    input  logic              step_n_b,
    input  logic              clr_n_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_b,
    output logic              rvalid_b
);
    rd_mode_e mode;
    assign mode = rd_mode_e'(flow_sel);

    logic              wen_a, wen_b;
    logic [ADDR_W-1:0] acc_a, acc_b;
    logic [DATA_W-1:0] wd_a, wd_b;
    logic [DATA_W-1:0] word_a, word_b;

    dpr_port #(.AW(ADDR_W), .DW(DATA_W)) u_port_a (
        .clk      (clk_a),
        .rst      (rst_a),
        .mode     (mode),
        .en_lo    (sel_n_a),
        .en_hi    (sel_a),
        .we       (we_a),
        .load_n   (load_n_a),
        .step_n   (step_n_a),
        .clr_n    (clr_n_a),
        .addr     (addr_a),
        .wdata    (wdata_a),
        .wr_en    (wen_a),
        .acc_addr (acc_a),
        .wr_data  (wd_a),
        .rd_word  (word_a),
        .rdata    (rdata_a),
        .rvalid   (rvalid_a)
    );

    dpr_port #(.AW(ADDR_W), .DW(DATA_W)) u_port_b (
        .clk      (clk_b),
        .rst      (rst_b),
        .mode     (mode),
        .en_lo    (sel_n_b),
        .en_hi    (sel_b),
        .we       (we_b),
        .load_n   (load_n_b),
        .step_n   (step_n_b),
        .clr_n    (clr_n_b),
        .addr     (addr_b),
        .wdata    (wdata_b),
        .wr_en    (wen_b),
        .acc_addr (acc_b),
        .wr_data  (wd_b),
        .rd_word  (word_b),
        .rdata    (rdata_b),
        .rvalid   (rvalid_b)
    );

    dpr_lvt_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk_a (clk_a),
        .we_a  (wen_a),
        .wa_a  (acc_a),
        .wd_a  (wd_a),
        .ra_a  (acc_a),
        .rd_a  (word_a),
        .clk_b (clk_b),
        .we_b  (wen_b),
        .wa_b  (acc_b),
        .wd_b  (wd_b),
        .ra_b  (acc_b),
        .rd_b  (word_b)
    );

endmodule

// File: rtl/burst_dpr_checker.sv
`timescale 1ns/1ps
module burst_dpr_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              flow_sel,
    input logic              clk_a,
    input logic              rst_a,
    input logic              sel_n_a,
    input logic              sel_a,
    input logic              we_a,
    input logic [DATA_W-1:0] rdata_a,
    input logic              rvalid_a,
    input logic              clk_b,
    input logic              rst_b,
    input logic              sel_n_b,
    input logic              sel_b,
    input logic              we_b,
    input logic [DATA_W-1:0] rdata_b,
    input logic              rvalid_b
);
    // R9
    flow_desel_a_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (flow_sel && $past(sel_n_a || !sel_a)) |-> (!rvalid_a && rdata_a == '0));

    // R9
    pipe_desel_a_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (!flow_sel && $past(sel_n_a || !sel_a, 2)) |-> (!rvalid_a && rdata_a == '0));

    // R10
    flow_wr_quiet_a_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (flow_sel && $past(we_a)) |-> !rvalid_a);

    // R10
    idle_zero_a_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        !rvalid_a |-> rdata_a == '0);

    // R9
    flow_desel_b_chk: assert property (@(posedge clk_b) disable iff (rst_b)
        (flow_sel && $past(sel_n_b || !sel_b)) |-> (!rvalid_b && rdata_b == '0));

    // R9
    pipe_desel_b_chk: assert property (@(posedge clk_b) disable iff (rst_b)
        (!flow_sel && $past(sel_n_b || !sel_b, 2)) |-> (!rvalid_b && rdata_b == '0));

    // R10
    flow_wr_quiet_b_chk: assert property (@(posedge clk_b) disable iff (rst_b)
        (flow_sel && $past(we_b)) |-> !rvalid_b);

    // R10
    idle_zero_b_chk: assert property (@(posedge clk_b) disable iff (rst_b)
        !rvalid_b |-> rdata_b == '0);

endmodule

bind burst_dual_port_ram burst_dpr_checker #(.DATA_W(DATA_W)) u_chk (
    .flow_sel (flow_sel),
    .clk_a    (clk_a),
    .rst_a    (rst_a),
    .sel_n_a  (sel_n_a),
    .sel_a    (sel_a),
    .we_a     (we_a),
    .rdata_a  (rdata_a),
    .rvalid_a (rvalid_a),
    .clk_b    (clk_b),
    .rst_b    (rst_b),
    .sel_n_b  (sel_n_b),
    .sel_b    (sel_b),
    .we_b     (we_b),
    .rdata_b  (rdata_b),
    .rvalid_b (rvalid_b)
);

// File: tb/test_burst_dual_port_ram.sv
`timescale 1ns/1ps
module test_burst_dual_port_ram;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NV = 8;

    // {address, data} pairs written then read back through the other port.
    localparam logic [AW+DW-1:0] VEC [NV] = '{
        {6'd3,  8'hA5}, {6'd17, 8'h3C}, {6'd63, 8'hE1}, {6'd0,  8'h5A},
        {6'd40, 8'h99}, {6'd9,  8'h07}, {6'd25, 8'hF0}, {6'd62, 8'h1B}
    };

    logic clk = 1'b0;
    logic rst;
    logic flow_sel;
    logic sel_n_a, sel_a, we_a, load_n_a, step_n_a, clr_n_a;
    logic sel_n_b, sel_b, we_b, load_n_b, step_n_b, clr_n_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [DW-1:0] wdata_a, wdata_b, rdata_a, rdata_b;
    logic rvalid_a, rvalid_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_dual_port_ram #(.ADDR_W(AW), .DATA_W(DW)) i_burst_dual_port_ram (
        .flow_sel (flow_sel),
        .clk_a (clk), .rst_a (rst), .sel_n_a (sel_n_a), .sel_a (sel_a),
        .we_a (we_a), .load_n_a (load_n_a), .step_n_a (step_n_a),
        .clr_n_a (clr_n_a), .addr_a (addr_a), .wdata_a (wdata_a),
        .rdata_a (rdata_a), .rvalid_a (rvalid_a),
        .clk_b (clk), .rst_b (rst), .sel_n_b (sel_n_b), .sel_b (sel_b),
        .we_b (we_b), .load_n_b (load_n_b), .step_n_b (step_n_b),
        .clr_n_b (clr_n_b), .addr_b (addr_b), .wdata_b (wdata_b),
        .rdata_b (rdata_b), .rvalid_b (rvalid_b)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Arguments: sel_n, sel, we, load_n, step_n, clr_n, addr, wdata
    task automatic set_a(input logic en_lo, input logic en_hi, input logic w,
                         input logic ld, input logic st, input logic cl,
                         input logic [AW-1:0] ad, input logic [DW-1:0] d);
        sel_n_a = en_lo; sel_a = en_hi; we_a = w;
        load_n_a = ld; step_n_a = st; clr_n_a = cl; addr_a = ad; wdata_a = d;
    endtask

    task automatic set_b(input logic en_lo, input logic en_hi, input logic w,
                         input logic ld, input logic st, input logic cl,
                         input logic [AW-1:0] ad, input logic [DW-1:0] d);
        sel_n_b = en_lo; sel_b = en_hi; we_b = w;
        load_n_b = ld; step_n_b = st; clr_n_b = cl; addr_b = ad; wdata_b = d;
    endtask

    task automatic idle_both();
        set_a(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
        set_b(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1;
        flow_sel = mode;
        idle_both();
        repeat (4) tick();
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // ---------------- flow-through phase ----------------
        do_reset(1'b1);
        chk("R11 rvalid_a after reset", {7'd0, rvalid_a}, 8'd0);
        chk("R11 rdata_a after reset", rdata_a, 8'd0);
        chk("R11 rvalid_b after reset", {7'd0, rvalid_b}, 8'd0);
        chk("R11 rdata_b after reset", rdata_b, 8'd0);

        // Vector walk: even entries written by A, odd by B (R1, R5)
        for (int i = 0; i < NV; i++) begin
            if (i % 2 == 0) set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
            else            set_b(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
            tick();
            if (i % 2 == 0) chk("R10 write access rvalid_a", {7'd0, rvalid_a}, 8'd0);
            idle_both();
            tick();
        end
        // Read back through the opposite port, flow-through (R1, R3)
        for (int i = 0; i < NV; i++) begin
            if (i % 2 == 0) set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, VEC[i][AW+DW-1:DW], '0);
            else            set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, VEC[i][AW+DW-1:DW], '0);
            tick();
            if (i % 2 == 0) begin
                chk("R1 cross-port read on B", rdata_b, VEC[i][DW-1:0]);
                chk("R3 same-cycle rvalid_b", {7'd0, rvalid_b}, 8'd1);
            end else begin
                chk("R1 cross-port read on A", rdata_a, VEC[i][DW-1:0]);
                chk("R3 same-cycle rvalid_a", {7'd0, rvalid_a}, 8'd1);
            end
            idle_both();
        end

        // R2: write commit timing against a concurrent flow-through read
        set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'd5, 8'h22);
        tick();
        idle_both();
        tick();
        set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'd5, 8'h11);
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd5, '0);
        tick();
        chk("R2 read in write capture cycle sees old word", rdata_b, 8'h22);
        idle_both();
        tick();
        chk("R2 read one edge later sees new word", rdata_b, 8'h11);

        // R1: simultaneous writes to different words, then crossed reads
        set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'd10, 8'h6A);
        set_b(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'd11, 8'h6B);
        tick();
        idle_both();
        tick();
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd11, '0);
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd10, '0);
        tick();
        chk("R1 simultaneous write seen on A", rdata_a, 8'h6B);
        chk("R1 simultaneous write seen on B", rdata_b, 8'h6A);
        idle_both();

        // R6: burst write on A from word 20, burst read on B
        set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'd20, 8'h80);
        tick();
        for (int k = 1; k < 4; k++) begin
            set_a(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd0, 8'h80 + 8'(k));
            tick();
        end
        idle_both();
        tick();
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd20, '0);
        tick();
        chk("R6 burst start word", rdata_b, 8'h80);
        for (int k = 1; k < 4; k++) begin
            set_b(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0);
            tick();
            chk("R6 burst next word", rdata_b, 8'h80 + 8'(k));
        end

        // R7: wrap from the last word to word 0
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd63, '0);
        tick();
        chk("R7 last word", rdata_b, 8'hE1);
        set_b(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0);
        tick();
        chk("R7 wrapped to word 0", rdata_b, 8'h5A);

        // R5: no strobe, bus changes, address held
        set_b(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd40, '0);
        tick();
        chk("R5 address bus ignored without load", rdata_b, 8'h5A);

        // R8: priority
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd17, '0);
        tick();
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd40, '0);
        tick();
        chk("R8 clear beats load and step", rdata_b, 8'h5A);
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd40, '0);
        tick();
        chk("R8 load beats step", rdata_b, 8'h99);
        // Counter steps while deselected, then read once selected
        set_b(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd16, '0);
        tick();
        set_b(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0);
        tick();
        set_b(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0, '0);
        tick();
        chk("R8 counter stepped while deselected", rdata_b, 8'h3C);
        idle_both();

        // R9: deselect in flow-through mode
        set_a(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd3, '0);
        tick();
        chk("R9 sel_n high rdata_a zero", rdata_a, 8'd0);
        chk("R9 sel_n high rvalid_a low", {7'd0, rvalid_a}, 8'd0);
        set_a(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd3, 8'h77);
        tick();
        chk("R9 sel low rvalid_a low", {7'd0, rvalid_a}, 8'd0);
        set_a(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0, '0);
        tick();
        tick();
        chk("R9 deselected write ignored", rdata_a, 8'hA5);
        idle_both();

        // ---------------- pipelined phase ----------------
        do_reset(1'b0);
        chk("R11 pipelined rvalid_a after reset", {7'd0, rvalid_a}, 8'd0);
        tick();
        chk("R4 output lags capture", {7'd0, rvalid_a}, 8'd0);
        tick();
        chk("R11 counter at word 0 after reset", rdata_a, 8'h5A);
        chk("R4 pipelined rvalid_a", {7'd0, rvalid_a}, 8'd1);
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd17, '0);
        tick();
        chk("R4 capture cycle shows previous word", rdata_a, 8'h5A);
        set_a(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0, '0);
        tick();
        chk("R4 word one clock after capture", rdata_a, 8'h3C);

        // R9: recovery after deselect in pipelined mode
        set_a(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0, '0);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd9, '0);
        tick();
        chk("R9 first selected capture still quiet", {7'd0, rvalid_a}, 8'd0);
        chk("R9 first selected capture rdata zero", rdata_a, 8'd0);
        set_a(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0, '0);
        tick();
        chk("R9 valid one clock later", {7'd0, rvalid_a}, 8'd1);
        chk("R9 recovered word", rdata_a, 8'h07);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule